// File: doc/BRIEF.md
# Display Adapter Host Register Block

This block is the host-side register front end of a raster display adapter. The host reaches it over an 8-bit bus with a 4-bit offset and separate read and write strobes. A single port at offset 10 serves an indexed register file. Writes to it alternate between loading an index and storing data at that index. Reading the same offset returns a status byte and puts the port back into its index phase, so host software can always find a known starting state.

A page register at offset 15 splits into a display page and a CPU-window page, each counted in 16 KB units. In 32 KB modes the lowest page bit is forced to zero. Two mode-control entries of the register file and the page register decode into three outputs: a display-format select, a CRT clock-divide select and a palette base. These outputs are registered and change one cycle after the write that affects them. Writes to the CRT controller address and data offsets appear as one-cycle strobes that carry the bus data.

Top module: `vidreg_top`

## Requirements
- R1: Successive writes to offset 10 alternate. The first write after reset loads the index, and the next stores its data into the register at that index. A read of offset 14 returns the register at the current index, or 0xFF when the index is 32 or above.
- R2: A read of offset 10 returns the port to its index phase, so the next write to offset 10 loads the index.
- R3: A read of offset 10 returns status. Bit 0 and bit 4 equal the display-enable input, bit 3 equals the vertical-sync input, and all other bits are 0.
- R4: A write to offset 0 or 4 pulses `crtc_addr_we`, and a write to offset 1 or 5 pulses `crtc_data_we`, both in the same cycle as the write. `crtc_wdata` carries the bus data. Other offsets raise neither strobe.
- R5: A read of any offset other than 10, 14 and 15 returns 0xFF.
- R6: Register indices 0x10 to 0x1F keep only the low 4 bits of the written data. Indices 0 to 0x0F keep all 8 bits.
- R7: Offset 15 writes the page register, and a read of offset 15 returns it. When bits 7:6 are not both 1, the display page equals bits 2:0 and the CPU page equals bits 5:3. Both take effect from the write edge.
- R8: When page bits 7:6 are both 1, the display page is bits 2:1 with bit 0 forced to 0, and the CPU page is bits 5:4 with its low bit forced to 0.
- R9: The format is decoded from bits 4, 3 and 1 of mode-control-1 (index 0). Pattern 0x08 gives text: `fmt_sel` 1, or 2 when mode-control-2 (index 3) bit 1 is set. Pattern 0x1A gives 4 bpp (`fmt_sel` 6). Every other pattern, 0x18 included, gives off (`fmt_sel` 0).
- R10: Pattern 0x0A gives 1 bpp (`fmt_sel` 3) when mode-control-1 bit 2 and mode-control-2 bit 3 are both set. Otherwise it gives plane-interleaved 2 bpp (`fmt_sel` 5) when page bits 7:6 are 11, and plain 2 bpp (`fmt_sel` 4) in all remaining cases.
- R11: `crt_div16` is 0 (divide by 8) when mode-control-1 bit 0 is set, and 1 (divide by 16) when it is clear. `pal_base` is 16 when mode-control-1 bit 2 is set, and 0 otherwise.
- R12: Format, divide and palette outputs reset to 0, 1 and 0. They change only on the second clock edge after a write to index 0, a write to index 3, or a write to the page register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_off | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, combinational from offset and state |
| vsync_in | input | 1 | Vertical sync from the CRT controller |
| de_in | input | 1 | Display enable from the CRT controller |
| crtc_addr_we | output | 1 | CRT controller address write strobe |
| crtc_data_we | output | 1 | CRT controller data write strobe |
| crtc_wdata | output | 8 | Data for the CRT controller |
| disp_page | output | 3 | Displayed page, 16 KB units |
| cpu_page | output | 3 | CPU window page, 16 KB units |
| fmt_sel | output | 3 | Display format: 0 off, 1 text, 2 blink text, 3 1 bpp, 4 2 bpp, 5 plane 2 bpp, 6 4 bpp |
| crt_div16 | output | 1 | 1 selects CRT clock divide by 16, 0 divide by 8 |
| pal_base | output | 5 | Palette base, 0 or 16 |

## Verification
Read data, status and CRT strobes are combinational, so they are compared in the same cycle as the strobe, at the falling edge while it is held. Page outputs and register contents are due one edge after the write. The mode outputs are due one edge later still. After such a write, the bench first checks that the old mode value is still present at the next falling edge, and only then checks for the new value one cycle on. Every expected value is queued by the driver and compared by a monitor at falling edges, so no comparison falls on the edge where the data changes.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;

  localparam int unsigned OFF_W      = 4;
  localparam int unsigned DATA_W     = 8;
  localparam logic [OFF_W-1:0] OFF_PORT = 4'd10;
  localparam logic [OFF_W-1:0] OFF_DATA = 4'd14;
  localparam logic [OFF_W-1:0] OFF_PAGE = 4'd15;

  typedef enum logic [2:0] {
    FMT_OFF        = 3'd0,
    FMT_TEXT       = 3'd1,
    FMT_TEXT_BLINK = 3'd2,
    FMT_MONO1      = 3'd3,
    FMT_COLOR2     = 3'd4,
    FMT_PLANE2     = 3'd5,
    FMT_COLOR4     = 3'd6
  } fmt_e;

  typedef struct packed {
    fmt_e       fmt;
    logic       div16;
    logic [4:0] pal_base;
  } mode_t;

  // mode decode from the two control entries and the page register
  function automatic mode_t decode_mode(input logic [7:0] mc1,
                                        input logic [7:0] mc2,
                                        input logic [7:0] pg);
    mode_t m;
    unique case ({mc1[4], mc1[3], mc1[1]})
      3'b010:  m.fmt = mc2[1] ? FMT_TEXT_BLINK : FMT_TEXT;
      3'b011: begin
        if (mc1[2] && mc2[3])      m.fmt = FMT_MONO1;
        else if (pg[7:6] == 2'b11) m.fmt = FMT_PLANE2;
        else                       m.fmt = FMT_COLOR2;
      end
      3'b111:  m.fmt = FMT_COLOR4;
      default: m.fmt = FMT_OFF;
    endcase
    m.div16    = ~mc1[0];
    m.pal_base = mc1[2] ? 5'd16 : 5'd0;
    return m;
  endfunction

  // a page field loses its low bit in 32K modes
  function automatic logic [2:0] page_field(input logic [2:0] f, input logic wide);
    return wide ? {f[2:1], 1'b0} : f;
  endfunction

endpackage

// File: rtl/vidreg_file.sv
module vidreg_file #(
  parameter int unsigned REG_COUNT = 32,
  parameter int unsigned NARROW_LO = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_wr,
  input  logic       port_rd,
  input  logic [7:0] wdata,
  output logic [7:0] sel_val,
  output logic [7:0] mc1,
  output logic [7:0] mc2,
  output logic       ctl_touch,
  output logic       data_phase
);
  localparam int unsigned IDX_W = $clog2(REG_COUNT);

  logic [7:0] index_q;
  logic [7:0] regs [REG_COUNT];
  logic       idx_in_range;
  logic       data_store;

  assign idx_in_range = (index_q < 8'(REG_COUNT));
  assign data_store   = port_wr && data_phase;
  assign ctl_touch    = data_store && (index_q == 8'd0 || index_q == 8'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_phase <= 1'b0;
      index_q    <= '0;
    end else if (port_wr) begin
      data_phase <= ~data_phase;
      if (!data_phase) index_q <= wdata;
    end else if (port_rd) begin
      data_phase <= 1'b0;
    end
  end

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_entry
    localparam logic [7:0] KEEP = (g >= NARROW_LO) ? 8'h0F : 8'hFF;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[g] <= '0;
      else if (data_store && idx_in_range && index_q[IDX_W-1:0] == IDX_W'(g))
        regs[g] <= wdata & KEEP;
    end
  end

  assign sel_val = idx_in_range ? regs[index_q[IDX_W-1:0]] : 8'hFF;
  assign mc1     = regs[0];
  assign mc2     = regs[3];
endmodule

// File: rtl/vidreg_page.sv
module vidreg_page (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [7:0] wdata,
  output logic [7:0] page_q,
  output logic [2:0] disp_page,
  output logic [2:0] cpu_page
);
  import vidreg_pkg::*;
  logic wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  page_q <= '0;
    else if (we) page_q <= wdata;
  end

  assign wide      = (page_q[7:6] == 2'b11);
  assign disp_page = page_field(page_q[2:0], wide);
  assign cpu_page  = page_field(page_q[5:3], wide);
endmodule

// File: rtl/vidreg_mode.sv
module vidreg_mode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       recalc_req,
  input  logic [7:0] mc1,
  input  logic [7:0] mc2,
  input  logic [7:0] page,
  output vidreg_pkg::mode_t mode_q,
  output logic       recalc_q
);
  import vidreg_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      recalc_q <= 1'b0;
      mode_q   <= '{fmt: FMT_OFF, div16: 1'b1, pal_base: 5'd0};
    end else begin
      recalc_q <= recalc_req;
      if (recalc_q) mode_q <= decode_mode(mc1, mc2, page);
    end
  end
endmodule

// File: rtl/vidreg_top.sv
module vidreg_top #(
  parameter int unsigned REG_COUNT = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] bus_off,
  input  logic [7:0] bus_wdata,
  input  logic       bus_wr,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  input  logic       vsync_in,
  input  logic       de_in,
  output logic       crtc_addr_we,
  output logic       crtc_data_we,
  output logic [7:0] crtc_wdata,
  output logic [2:0] disp_page,
  output logic [2:0] cpu_page,
  output logic [2:0] fmt_sel,
  output logic       crt_div16,
  output logic [4:0] pal_base
);
  import vidreg_pkg::*;

  logic       port_wr, port_rd, page_we;
  logic       ctl_touch, data_phase, recalc_q;
  logic [7:0] sel_val, mc1, mc2, page_q, status;
  mode_t      mode_q;

  assign port_wr = bus_wr && bus_off == OFF_PORT;
  assign port_rd = bus_rd && bus_off == OFF_PORT;
  assign page_we = bus_wr && bus_off == OFF_PAGE;

  vidreg_file #(.REG_COUNT(REG_COUNT)) u_file (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_rd(port_rd),
    .wdata(bus_wdata), .sel_val(sel_val), .mc1(mc1), .mc2(mc2),
    .ctl_touch(ctl_touch), .data_phase(data_phase)
  );

  vidreg_page u_page (
    .clk(clk), .rst_n(rst_n), .we(page_we), .wdata(bus_wdata),
    .page_q(page_q), .disp_page(disp_page), .cpu_page(cpu_page)
  );

  vidreg_mode u_mode (
    .clk(clk), .rst_n(rst_n), .recalc_req(ctl_touch || page_we),
    .mc1(mc1), .mc2(mc2), .page(page_q), .mode_q(mode_q), .recalc_q(recalc_q)
  );

  assign status = {3'b000, de_in, vsync_in, 2'b00, de_in};

  always_comb begin
    unique case (bus_off)
      OFF_PORT: bus_rdata = status;
      OFF_DATA: bus_rdata = sel_val;
      OFF_PAGE: bus_rdata = page_q;
      default:  bus_rdata = 8'hFF;
    endcase
  end

  assign crtc_addr_we = bus_wr && (bus_off == 4'd0 || bus_off == 4'd4);
  assign crtc_data_we = bus_wr && (bus_off == 4'd1 || bus_off == 4'd5);
  assign crtc_wdata   = bus_wdata;

  assign fmt_sel   = mode_q.fmt;
  assign crt_div16 = mode_q.div16;
  assign pal_base  = mode_q.pal_base;
endmodule

// File: rtl/vidreg_checker.sv
module vidreg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] bus_off,
  input logic       bus_wr,
  input logic       bus_rd,
  input logic [7:0] bus_rdata,
  input logic       vsync_in,
  input logic       de_in,
  input logic       data_phase,
  input logic       recalc_q,
  input logic [7:0] page_q,
  input logic [2:0] disp_page,
  input logic [2:0] cpu_page,
  input logic [2:0] fmt_sel,
  input logic [4:0] pal_base,
  input logic       crtc_addr_we,
  input logic       crtc_data_we
);
  a_r1_toggle_flips: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_off == 4'd10) |=> (data_phase != $past(data_phase)));

  a_r2_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_off == 4'd10) |=> !data_phase);

  a_r3_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_off == 4'd10) |->
      (bus_rdata[3] == vsync_in && bus_rdata[0] == de_in && bus_rdata[4] == de_in));

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    (crtc_addr_we || crtc_data_we) |-> (bus_wr && !(crtc_addr_we && crtc_data_we)));

  a_r8_wide_pages_even: assert property (@(posedge clk) disable iff (!rst_n)
    (page_q[7:6] == 2'b11) |-> (!disp_page[0] && !cpu_page[0]));

  a_r11_pal_values: assert property (@(posedge clk) disable iff (!rst_n)
    (pal_base == 5'd0 || pal_base == 5'd16));

  a_r12_mode_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !recalc_q |=> ($stable(fmt_sel) && $stable(pal_base)));
endmodule

bind vidreg_top vidreg_checker u_chk (
  .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .vsync_in(vsync_in), .de_in(de_in),
  .data_phase(data_phase), .recalc_q(recalc_q), .page_q(page_q),
  .disp_page(disp_page), .cpu_page(cpu_page), .fmt_sel(fmt_sel),
  .pal_base(pal_base), .crtc_addr_we(crtc_addr_we), .crtc_data_we(crtc_data_we)
);

// File: tb/vidreg_top_tb_top.sv
module vidreg_top_tb_top;
  localparam int K_RD = 0, K_FMT = 1, K_DIV = 2, K_PAL = 3, K_DP = 4, K_CP = 5,
                 K_STB = 6, K_CW = 7;

  typedef struct {
    int         kind;
    logic [7:0] exp;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] bus_off = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
  logic [7:0] bus_rdata, crtc_wdata;
  logic       crtc_addr_we, crtc_data_we, crt_div16;
  logic [2:0] disp_page, cpu_page, fmt_sel;
  logic [4:0] pal_base;

  item_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vidreg_top dut_i (
    .clk(clk), .rst_n(rst_n), .bus_off(bus_off), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .vsync_in(vsync_in), .de_in(de_in), .crtc_addr_we(crtc_addr_we),
    .crtc_data_we(crtc_data_we), .crtc_wdata(crtc_wdata),
    .disp_page(disp_page), .cpu_page(cpu_page), .fmt_sel(fmt_sel),
    .crt_div16(crt_div16), .pal_base(pal_base)
  );

  function automatic logic [7:0] observe(int kind);
    case (kind)
      K_RD:    return bus_rdata;
      K_FMT:   return {5'd0, fmt_sel};
      K_DIV:   return {7'd0, crt_div16};
      K_PAL:   return {3'd0, pal_base};
      K_DP:    return {5'd0, disp_page};
      K_CP:    return {5'd0, cpu_page};
      K_STB:   return {6'd0, crtc_data_we, crtc_addr_we};
      default: return crtc_wdata;
    endcase
  endfunction

  // monitor: compares queued expectations at falling edges
  initial forever begin
    @(negedge clk);
    while (q.size() > 0) begin
      item_t it;
      logic [7:0] act;
      it  = q.pop_front();
      act = observe(it.kind);
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s kind %0d: actual 0x%02h expected 0x%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic push(int kind, logic [7:0] exp, string req);
    item_t it;
    it.kind = kind; it.exp = exp; it.req = req;
    q.push_back(it);
  endtask

  task automatic chk(int kind, logic [7:0] exp, string req);
    push(kind, exp, req);
    tick();
  endtask

  task automatic wr(logic [3:0] off, logic [7:0] d);
    bus_off = off; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [3:0] off, logic [7:0] exp, string req);
    bus_off = off; bus_rd = 1'b1;
    push(K_RD, exp, req);
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic put(logic [7:0] idx, logic [7:0] d);
    wr(4'd10, idx);
    wr(4'd10, d);
  endtask

  // mode value is due on the second edge after the write
  task automatic mode_chk(logic [2:0] f, logic dv, logic [4:0] pb, string req);
    tick();
    chk(K_FMT, {5'd0, f}, req);
    chk(K_DIV, {7'd0, dv}, req);
    chk(K_PAL, {3'd0, pb}, req);
  endtask

  function automatic logic [7:0] exp_disp(logic [7:0] pg);
    return (pg[7:6] == 2'b11) ? (pg & 8'h06) : (pg & 8'h07);
  endfunction
  function automatic logic [7:0] exp_cpu(logic [7:0] pg);
    return (pg >> 3) & ((pg[7:6] == 2'b11) ? 8'h06 : 8'h07);
  endfunction

  task automatic page_chk(logic [7:0] pg, string req);
    wr(4'd15, pg);
    chk(K_DP, exp_disp(pg), req);
    chk(K_CP, exp_cpu(pg), req);
    rd_chk(4'd15, pg, req);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick();
    // R12 reset values
    chk(K_FMT, 8'd0, "R12 reset fmt");
    chk(K_DIV, 8'd1, "R12 reset div");
    chk(K_PAL, 8'd0, "R12 reset pal");
    chk(K_DP, 8'd0, "R7 reset disp");
    rd_chk(4'd10, 8'h00, "R3 idle status");

    // R1 index then data
    put(8'h02, 8'hA5);
    rd_chk(4'd14, 8'hA5, "R1 data readback");
    put(8'h40, 8'h11);
    rd_chk(4'd14, 8'hFF, "R1 index out of range");

    // R6 narrow palette entries
    put(8'h13, 8'hFB);
    rd_chk(4'd14, 8'h0B, "R6 palette low nibble");
    put(8'h01, 8'hFB);
    rd_chk(4'd14, 8'hFB, "R6 full byte entry");

    // R2 status read resets the toggle
    wr(4'd10, 8'h05);
    rd_chk(4'd10, 8'h00, "R2 status read");
    put(8'h02, 8'h3C);
    rd_chk(4'd14, 8'h3C, "R2 toggle back to index");

    // R3 status bits
    vsync_in = 1'b1; de_in = 1'b0;
    rd_chk(4'd10, 8'h08, "R3 vsync only");
    vsync_in = 1'b0; de_in = 1'b1;
    rd_chk(4'd10, 8'h11, "R3 de only");
    vsync_in = 1'b1;
    rd_chk(4'd10, 8'h19, "R3 both");
    vsync_in = 1'b0; de_in = 1'b0;

    // R4 CRT strobes, checked while the write is held
    bus_wr = 1'b1; bus_wdata = 8'h5A;
    bus_off = 4'd0; push(K_STB, 8'h01, "R4 off0 addr"); push(K_CW, 8'h5A, "R4 wdata"); tick();
    bus_off = 4'd4; push(K_STB, 8'h01, "R4 off4 addr"); tick();
    bus_off = 4'd5; push(K_STB, 8'h02, "R4 off5 data"); tick();
    bus_off = 4'd1; push(K_STB, 8'h02, "R4 off1 data"); tick();
    bus_off = 4'd3; push(K_STB, 8'h00, "R4 off3 none"); tick();
    bus_wr = 1'b0;

    // R5 unmapped reads
    rd_chk(4'd0, 8'hFF, "R5 off0");
    rd_chk(4'd7, 8'hFF, "R5 off7");
    rd_chk(4'd11, 8'hFF, "R5 off11");

    // R7 and R8 page register
    page_chk(8'h2B, "R7 normal page");
    page_chk(8'h40, "R7 bit6 only");
    page_chk(8'hFF, "R8 wide page");
    page_chk(8'hC9, "R8 wide odd");
    wr(4'd15, 8'h00);

    // R9 text and R12 timing
    put(8'h00, 8'h08);
    push(K_FMT, 8'd0, "R12 not yet updated");
    mode_chk(3'd1, 1'b1, 5'd0, "R9 text");
    put(8'h03, 8'h02);
    mode_chk(3'd2, 1'b1, 5'd0, "R9 blink text");
    put(8'h00, 8'h1A);
    mode_chk(3'd6, 1'b1, 5'd0, "R9 4bpp");
    put(8'h00, 8'h18);
    mode_chk(3'd0, 1'b1, 5'd0, "R9 pattern 0x18 off");
    put(8'h03, 8'h00);
    put(8'h00, 8'h0A);
    mode_chk(3'd4, 1'b1, 5'd0, "R10 2bpp");
    wr(4'd15, 8'hC0);
    push(K_FMT, 8'd4, "R12 page not yet");
    mode_chk(3'd5, 1'b1, 5'd0, "R10 plane 2bpp");
    wr(4'd15, 8'h00);
    put(8'h03, 8'h08);
    put(8'h00, 8'h0E);
    mode_chk(3'd3, 1'b1, 5'd16, "R10 1bpp");
    // R12 writes to other indices leave mode alone
    put(8'h01, 8'h00);
    mode_chk(3'd3, 1'b1, 5'd16, "R12 unrelated index");
    put(8'h00, 8'h09);
    mode_chk(3'd1, 1'b0, 5'd0, "R11 divide 8");
    put(8'h00, 8'h0C);
    mode_chk(3'd1, 1'b1, 5'd16, "R11 grey palette");

    tick();
    done = 1;
    summary();
    $finish;
  end
endmodule